// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block synchronizes a fixed group of participants at a barrier in hardware. Each participant owns one bit of an arrival input. A one-cycle pulse on that bit says the participant has reached the barrier. Each participant also owns one bit of a release output, which says it may go on.

Inside, each participant keeps a private sense bit and the unit keeps one shared episode flag. On arrival a participant flips its private sense. From that moment it is held, because its sense no longer matches the shared flag. A shared counter records how many participants are held. The arrival, or group of same-cycle arrivals, that fills the count clears the counter and flips the shared flag. That makes every private sense match the flag again, so all participants are released together.

The value that means "released" alternates from one episode to the next. The barrier can therefore be reused straight away, with no separate exit phase. A participant that races ahead cannot pass the next barrier before the slower ones have left the current one.

Top module: `sense_barrier_unit`

## Requirements
- R1: While `rst_n` is low, and after it returns high, `release_o` is all zeros and no participant is counted, whatever the state before reset. After a reset, one arrival from every participant completes an episode.
- R2: A participant whose bit of `arrive_i` is high in a cycle in which it is not held becomes held. If that arrival does not complete the episode, its `release_o` bit is low from the next cycle on, until the episode completes.
- R3: Arrivals from fewer than `NUM_PART` distinct participants within one episode never raise any `release_o` bit of a held participant. The held count always equals the number of held participants and stays below `NUM_PART`.
- R4: The cycle in which the number of held participants reaches `NUM_PART` completes the episode. In the next cycle every `release_o` bit is high, and that includes the bit of the participant that arrived last.
- R5: Arrivals from several participants in the same cycle are all counted. If together they fill the count, the episode completes in that cycle, including the case where every participant arrives at once.
- R6: An arrival pulse from a participant that is already held is ignored. It neither counts toward completion nor changes that participant's held state, and this holds even in the cycle in which other arrivals complete the episode.
- R7: Episodes run back to back. After a completion, a released participant's new arrival lowers its `release_o` bit and starts the next episode, while the bits of the others stay high.
- R8: A participant's `release_o` bit stays high from its release until its next arrival. The bit of a participant that has never arrived since reset is low.

Top module port list follows (bit i of each vector belongs to participant i; arrivals are active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive_i | input | NUM_PART | Arrival pulses, one bit per participant |
| release_o | output | NUM_PART | Release indication, one bit per participant |

## Verification
A wrong count or a wrong private sense shows at the ports within one episode. A miscount releases the group one arrival early or late, or never releases it. A sense bit that fails to flip leaves a participant released while it should be held, visible the cycle after its arrival. A shared flag that toggles at the wrong time raises or drops every release bit together in the cycle after the faulty edge. The bench therefore checks `release_o` after every stimulus cycle, so any such error is caught no later than the cycle after the completing arrival.

// File: rtl/sr_barrier_pkg.sv
package sr_barrier_pkg;

  // Largest group size the counting helpers accept.
  localparam int unsigned MAX_PART = 64;

  // Number of set bits in a (zero-extended) arrival vector.
  function automatic int unsigned count_ones(input logic [MAX_PART-1:0] vec);
    int unsigned total;
    total = 0;
    for (int k = 0; k < MAX_PART; k++) begin
      total += int'(vec[k]);
    end
    return total;
  endfunction

  // Held count after this cycle's accepted arrivals, before wrap.
  function automatic int unsigned next_total(input int unsigned held,
                                             input logic [MAX_PART-1:0] accepted);
    return held + count_ones(accepted);
  endfunction

endpackage

// File: rtl/sr_sense_slot.sv
// One participant: private sense bit plus a "has ever arrived" marker.
module sr_sense_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic global_flag,
  output logic accept,
  output logic waiting,
  output logic local_sense,
  output logic release_out
);

  logic sense_q;
  logic seen_q;

  // Held while the private sense differs from the episode flag.
  assign waiting     = sense_q ^ global_flag;
  assign accept      = arrive & ~waiting;
  assign release_out = seen_q & ~waiting;
  assign local_sense = sense_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (accept) begin
      sense_q <= ~sense_q;
      seen_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/sr_arrival_counter.sv
// Counts held participants; flags the cycle that fills the group.
module sr_arrival_counter #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned CNT_W    = $clog2(NUM_PART + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] accepted,
  output logic [CNT_W-1:0]    count_q,
  output logic                complete
);

  import sr_barrier_pkg::*;

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [MAX_PART-1:0] accepted_wide;
  logic [SUM_W-1:0]    sum;

  assign accepted_wide = MAX_PART'(accepted);
  assign sum           = SUM_W'(next_total(int'(count_q), accepted_wide));
  assign complete      = (sum == SUM_W'(NUM_PART));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (complete) begin
      count_q <= '0;
    end else begin
      count_q <= CNT_W'(sum);
    end
  end

endmodule

// File: rtl/sr_episode_flag.sv
// Shared episode flag: flips once per completed episode.
module sr_episode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic complete,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (complete) begin
      flag_q <= ~flag_q;
    end
  end

endmodule

// File: rtl/sense_barrier_unit.sv
module sense_barrier_unit #(
  parameter int unsigned NUM_PART = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] arrive_i,
  output logic [NUM_PART-1:0] release_o
);

  localparam int unsigned CNT_W = $clog2(NUM_PART + 1);

  // Named internal events, brought out for the checker.
  logic [NUM_PART-1:0] accepted;
  logic [NUM_PART-1:0] waiting;
  logic [NUM_PART-1:0] local_sense;
  logic [CNT_W-1:0]    count_q;
  logic                complete;
  logic                global_flag;

  generate
    for (genvar g = 0; g < NUM_PART; g++) begin : g_slot
      sr_sense_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .arrive      (arrive_i[g]),
        .global_flag (global_flag),
        .accept      (accepted[g]),
        .waiting     (waiting[g]),
        .local_sense (local_sense[g]),
        .release_out (release_o[g])
      );
    end
  endgenerate

  sr_arrival_counter #(
    .NUM_PART (NUM_PART),
    .CNT_W    (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .accepted (accepted),
    .count_q  (count_q),
    .complete (complete)
  );

  sr_episode_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .complete (complete),
    .flag_q   (global_flag)
  );

endmodule

// File: rtl/sr_barrier_checker.sv
module sr_barrier_checker #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned CNT_W    = $clog2(NUM_PART + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PART-1:0] arrive_i,
  input logic [NUM_PART-1:0] release_o,
  input logic [NUM_PART-1:0] accepted,
  input logic [NUM_PART-1:0] waiting,
  input logic [NUM_PART-1:0] local_sense,
  input logic [CNT_W-1:0]    count_q,
  input logic                complete,
  input logic                global_flag
);

  assert_count_tracks_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q == CNT_W'($countones(waiting)));

  assert_count_below_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < CNT_W'(NUM_PART));

  assert_partial_arrival_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((accepted != '0) && !complete) |=> ((release_o & $past(accepted)) == '0));

  assert_all_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (release_o == '1));

  assert_flag_only_on_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(global_flag));

  assert_dup_arrival_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((arrive_i & waiting) != '0) |=>
      (((local_sense ^ $past(local_sense)) & $past(arrive_i & waiting)) == '0));

  assert_everyone_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (waiting == '0));

endmodule

bind sense_barrier_unit sr_barrier_checker #(
  .NUM_PART (NUM_PART)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arrive_i    (arrive_i),
  .release_o   (release_o),
  .accepted    (accepted),
  .waiting     (waiting),
  .local_sense (local_sense),
  .count_q     (count_q),
  .complete    (complete),
  .global_flag (global_flag)
);

// File: tb/tb_sense_barrier_unit.sv
`timescale 1ns/1ps
module tb_sense_barrier_unit;

  localparam int unsigned NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] arrive_i = '0;
  logic [NP-1:0] release_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  sense_barrier_unit #(.NUM_PART(NP)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive_i),
    .release_o (release_o)
  );

  // {requirement number, arrive pattern, expected release one cycle later}
  localparam int NVEC = 15;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd2, 4'b0001, 4'b0000},  // R2: first arrival, held
    {4'd6, 4'b0001, 4'b0000},  // R6: duplicate while held
    {4'd3, 4'b0110, 4'b0000},  // R3: three of four, still held
    {4'd6, 4'b0001, 4'b0000},  // R6: duplicate does not complete
    {4'd4, 4'b1000, 4'b1111},  // R4: last arrival releases all
    {4'd8, 4'b0000, 4'b1111},  // R8: release persists
    {4'd7, 4'b0010, 4'b1101},  // R7: next episode begins
    {4'd6, 4'b0010, 4'b1101},  // R6: duplicate in new episode
    {4'd5, 4'b1101, 4'b1111},  // R5: three together complete
    {4'd5, 4'b1111, 4'b1111},  // R5: all four at once
    {4'd7, 4'b0100, 4'b1011},  // R7
    {4'd5, 4'b1011, 4'b1111},  // R5
    {4'd2, 4'b0001, 4'b1110},  // R2
    {4'd3, 4'b0011, 4'b1100},  // R3: one new, one duplicate
    {4'd6, 4'b1101, 4'b1111}   // R6: duplicate beside completing arrivals
  };

  task automatic check(input string req, input logic [NP-1:0] exp);
    checks++;
    if (release_o !== exp) begin
      errors++;
      $display("FAIL %s: release_o=%b expected=%b", req, release_o, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next fall.
  task automatic step(input logic [NP-1:0] arr);
    arrive_i = arr;
    @(negedge clk);
    arrive_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0);                       // R1: held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0);                       // R1: after reset
    step(4'b0000);
    check("R8", '0);                       // R8: never arrived, low

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][7:4]);
      check($sformatf("R%0d", VEC[v][11:8]), VEC[v][3:0]);
    end

    // R1: reset in mid-episode clears held state and count
    step(4'b0110);
    check("R2", 4'b1001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    step(4'b0011);
    check("R1", '0);
    step(4'b1100);
    check("R1", 4'b1111);

    // R3: repeated pulses from only three participants never release
    step(4'b0111);
    for (int k = 0; k < 5; k++) begin
      step(4'b0111);
      check("R3", 4'b1000);
    end
    step(4'b1000);
    check("R4", 4'b1111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: release_o=%b expected=completion", release_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule